// File: doc/BRIEF.md
# Dual-Domain Scan Shift and Capture Clock Sequencer

This block drives the test clocks of two clock domains while logic self-test runs on chip. The clocks are given as one enable per domain, to be fed to the domain's clock-gating cell. After a start request the block first loads the scan chains. Each domain receives the programmed number of shift pulses while its scan enable is high. Next, each domain's scan enable drops on that domain's own schedule. Last, every domain gets an at-speed capture pulse on one common control-clock edge. Any domain can ask for a second capture pulse on the following edge.

Any domain can be marked as leading. A leading domain shifts one control cycle earlier than the other domains, so its final shift pulse comes one cycle before theirs. This gives the leading domain an extra cycle between its last shift and the shared capture edge, which suits a domain whose scan-enable network settles slowly. The shift length, the leading mask and the double-capture mask are sampled when the start request is accepted. A one-cycle done strobe closes the sequence, and every scan enable is high again at that point, ready for the next load.

Top module: `scan_clk_ctrl`

## Requirements
- R1: In the cycle after reset is released, every domain clock enable is 0, every scan enable is 1 and done is 0.
- R2: While no sequence is running, every domain clock enable stays 0 and every scan enable stays 1.
- R3: A start request with a nonzero shift length L (1 to 1023) gives each domain exactly L shift pulses, meaning cycles with both its clock enable and its scan enable at 1.
- R4: Count cycles from 0, where cycle 0 is the first cycle after the clock edge that accepts the start request. A domain whose bit is 1 in the leading mask shifts in cycles 0 to L-1. Every other domain shifts in cycles 1 to L.
- R5: A domain's scan enable goes to 0 in the cycle after its own last shift pulse and stays 0 until done.
- R6: Cycle L+1 carries no clock pulse in any domain. In cycle L+2, every domain gets its first capture pulse (clock enable 1, scan enable 0).
- R7: A domain whose bit is 1 in the double-capture mask gets a second capture pulse in cycle L+3. In that cycle, all other domains have their clock enable at 0.
- R8: Done is 1 for exactly one cycle, the cycle right after the final capture pulse (cycle L+3, or L+4 when any double-capture bit is set). All scan enables are already 1 in that cycle.
- R9: A start request that arrives while a sequence is running is ignored. Changes to the shift length or the masks after acceptance do not affect the running sequence.
- R10: A start request with a shift length of 0 is ignored, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a load-and-capture sequence |
| shift_len | input | LEN_W | Number of shift pulses per domain |
| cap_twice | input | NDOM | Per-domain request for a second capture pulse |
| lead_dom | input | NDOM | Per-domain flag: shift one cycle early |
| dom_clk_en | output | NDOM | Per-domain clock enable for the gating cell |
| dom_se | output | NDOM | Per-domain scan enable |
| done | output | 1 | One-cycle strobe at the end of a sequence |

## Verification
The bench uses the default parameters: two domains and a 10-bit shift length. With these values it can compare every pair of leading and double-capture masks, cycle by cycle, against a waveform derived from the requirements. The default width also makes the 1023-pulse maximum shift length reachable, and the bench runs it in full. The shortest length of one pulse is run as well; at that length a leading domain's scan enable drops in cycle 1, leaving a two-cycle low window before the shared capture.

// File: rtl/scan_clk_pkg.sv
package scan_clk_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SHIFT,
        PH_GAP,
        PH_CAP1,
        PH_CAP2,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic en;
        logic se;
    } dom_drive_t;

    // Drive for one domain while chains are loading.
    function automatic dom_drive_t shift_drive(logic lead, logic at_first, logic at_last);
        dom_drive_t d;
        if (lead) begin
            d.en = !at_last;
            d.se = !at_last;
        end else begin
            d.en = !at_first;
            d.se = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
    import scan_clk_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int NDOM  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] shift_len,
    input  logic [NDOM-1:0]  cap_twice,
    input  logic [NDOM-1:0]  lead_dom,
    output phase_e           phase,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] len_q,
    output logic [NDOM-1:0]  cap2_q,
    output logic [NDOM-1:0]  lead_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            len_q  <= '0;
            cap2_q <= '0;
            lead_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start && shift_len != '0) begin
                        len_q  <= shift_len;
                        cap2_q <= cap_twice;
                        lead_q <= lead_dom;
                        cnt    <= '0;
                        phase  <= PH_SHIFT;
                    end
                end
                PH_SHIFT: begin
                    if (cnt == len_q) phase <= PH_GAP;
                    else              cnt   <= cnt + 1'b1;
                end
                PH_GAP:  phase <= PH_CAP1;
                PH_CAP1: phase <= (|cap2_q) ? PH_CAP2 : PH_DONE;
                PH_CAP2: phase <= PH_DONE;
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3: shift counter never runs past the latched length
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SHIFT) |-> (cnt <= len_q));

    // R9: latched configuration holds while a sequence runs
    a_r9_cfg_held: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |->
            ($stable(len_q) && $stable(cap2_q) && $stable(lead_q)));

endmodule

// File: rtl/scan_dom_gate.sv
module scan_dom_gate
    import scan_clk_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic [LEN_W-1:0] cnt,
    input  logic [LEN_W-1:0] len_q,
    input  logic             lead,
    input  logic             cap2,
    output logic             clk_en,
    output logic             se
);

    dom_drive_t drv;

    always_comb begin
        drv = '{en: 1'b0, se: 1'b1};
        unique case (phase)
            PH_SHIFT: drv = shift_drive(lead, cnt == '0, cnt == len_q);
            PH_GAP:   drv = '{en: 1'b0, se: 1'b0};
            PH_CAP1:  drv = '{en: 1'b1, se: 1'b0};
            PH_CAP2:  drv = '{en: cap2, se: 1'b0};
            default:  drv = '{en: 1'b0, se: 1'b1};
        endcase
    end

    assign clk_en = drv.en;
    assign se     = drv.se;

    // R5: a capture pulse is always preceded by a cycle with scan enable low
    a_r5_se_low_before_capture: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !se) |-> !$past(se));

endmodule

// File: rtl/scan_clk_ctrl.sv
module scan_clk_ctrl
    import scan_clk_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int NDOM  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] shift_len,
    input  logic [NDOM-1:0]  cap_twice,
    input  logic [NDOM-1:0]  lead_dom,
    output logic [NDOM-1:0]  dom_clk_en,
    output logic [NDOM-1:0]  dom_se,
    output logic             done
);

    phase_e           phase;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic [NDOM-1:0]  cap2_q;
    logic [NDOM-1:0]  lead_q;

    scan_seq_fsm #(.LEN_W(LEN_W), .NDOM(NDOM)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .shift_len (shift_len),
        .cap_twice (cap_twice),
        .lead_dom  (lead_dom),
        .phase     (phase),
        .cnt       (cnt),
        .len_q     (len_q),
        .cap2_q    (cap2_q),
        .lead_q    (lead_q)
    );

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        scan_dom_gate #(.LEN_W(LEN_W)) u_gate (
            .clk    (clk),
            .rst    (rst),
            .phase  (phase),
            .cnt    (cnt),
            .len_q  (len_q),
            .lead   (lead_q[d]),
            .cap2   (cap2_q[d]),
            .clk_en (dom_clk_en[d]),
            .se     (dom_se[d])
        );
    end

    assign done = (phase == PH_DONE);

    // R2: idle means quiet clocks and loaded scan enables
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (dom_clk_en == '0 && (&dom_se)));

    // R6: first capture is common to all domains
    a_r6_capture_aligned: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CAP1) |-> ((&dom_clk_en) && dom_se == '0));

    // R8: done lasts a single cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: scan enables are back high with done
    a_r8_se_restored: assert property (@(posedge clk) disable iff (rst)
        done |-> ((&dom_se) && dom_clk_en == '0));

endmodule

// File: tb/tb_scan_clk_ctrl.sv
module tb_scan_clk_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 10;
    localparam int NDOM  = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [LEN_W-1:0] shift_len = '0;
    logic [NDOM-1:0]  cap_twice = '0;
    logic [NDOM-1:0]  lead_dom = '0;
    logic [NDOM-1:0]  dom_clk_en;
    logic [NDOM-1:0]  dom_se;
    logic             done;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_clk_ctrl #(.LEN_W(LEN_W), .NDOM(NDOM)) dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .shift_len  (shift_len),
        .cap_twice  (cap_twice),
        .lead_dom   (lead_dom),
        .dom_clk_en (dom_clk_en),
        .dom_se     (dom_se),
        .done       (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dom_clk_en == '0, "R1", "clk_en after reset", int'(dom_clk_en), 0);
        chk(dom_se == '1, "R1", "se after reset", int'(dom_se), 3);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    endtask

    // Full cycle-by-cycle check of one sequence against the requirements.
    task automatic run_case(input int len, input logic [NDOM-1:0] lead,
                            input logic [NDOM-1:0] c2, input bit disturb);
        int total;
        int t_done;
        int shifts [NDOM];
        @(negedge clk);
        shift_len = LEN_W'(len);
        lead_dom  = lead;
        cap_twice = c2;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t_done = (c2 != '0) ? len + 4 : len + 3;
        total  = t_done + 5;
        for (int d = 0; d < NDOM; d++) shifts[d] = 0;
        for (int t = 0; t <= total; t++) begin
            if (t > 0) @(negedge clk);
            for (int d = 0; d < NDOM; d++) begin
                logic e_en, e_se;
                string req;
                if (t <= len) begin
                    req  = "R4";
                    e_en = lead[d] ? (t < len) : (t >= 1);
                    e_se = lead[d] ? (t < len) : 1'b1;
                end else if (t == len + 1) begin
                    req = "R6"; e_en = 1'b0; e_se = 1'b0;
                end else if (t == len + 2) begin
                    req = "R6"; e_en = 1'b1; e_se = 1'b0;
                end else if (t == len + 3 && c2 != '0) begin
                    req = "R7"; e_en = c2[d]; e_se = 1'b0;
                end else if (t == t_done) begin
                    req = "R8"; e_en = 1'b0; e_se = 1'b1;
                end else begin
                    req = "R2"; e_en = 1'b0; e_se = 1'b1;
                end
                if (dom_clk_en[d] && dom_se[d]) shifts[d]++;
                chk(dom_clk_en[d] == e_en, req, $sformatf("clk_en dom%0d cycle %0d", d, t),
                    int'(dom_clk_en[d]), int'(e_en));
                chk(dom_se[d] == e_se, (t <= len + 1) ? "R5" : req,
                    $sformatf("se dom%0d cycle %0d", d, t), int'(dom_se[d]), int'(e_se));
            end
            chk(done == (t == t_done), "R8", $sformatf("done cycle %0d", t),
                int'(done), int'(t == t_done));
            if (disturb) begin
                if (t == 1) begin
                    shift_len = ~LEN_W'(len);
                    lead_dom  = ~lead;
                    cap_twice = ~c2;
                end
                if (t == 3) start = 1'b1;
                if (t == 4) start = 1'b0;
            end
        end
        for (int d = 0; d < NDOM; d++)
            chk(shifts[d] == len, disturb ? "R9" : "R3",
                $sformatf("shift pulse count dom%0d", d), shifts[d], len);
    endtask

    task automatic test_zero_len();
        @(negedge clk);
        shift_len = '0;
        cap_twice = '1;
        lead_dom  = '0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 6; t++) begin
            if (t > 0) @(negedge clk);
            chk(dom_clk_en == '0 && dom_se == '1 && !done, "R10",
                $sformatf("zero length start cycle %0d", t),
                int'({done, dom_clk_en, dom_se}), 3);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        run_case(5, 2'b01, 2'b00, 1'b0);
        run_case(5, 2'b10, 2'b01, 1'b0);
        run_case(1, 2'b01, 2'b10, 1'b0);
        run_case(2, 2'b00, 2'b11, 1'b0);
        run_case(3, 2'b11, 2'b00, 1'b0);
        run_case(4, 2'b01, 2'b10, 1'b1);
        test_zero_len();
        run_case(1023, 2'b10, 2'b01, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule